// File: doc/BRIEF.md
# Pixel Array Frame Sequencer and Serial Readout

This block runs a single row of time-to-digital pixels through one measurement frame at a time. On a frame-start request it arms every pixel together. After a fixed quantization window it sends one shared stop strobe, and on the reference-clock edge after that strobe it captures every pixel's hit flag and time code into one snapshot. It then hands the snapshot to a serializer that runs on the faster transmission clock. The serializer marks the frame with a one-cycle sync pulse and shifts the whole payload out on one data line, qualified by a valid signal.

The two clock domains exchange only two handshake levels, and each level passes through a two-flop synchronizer. The reference side keeps a transmit request high until the serializer's completion level comes back, and only then does it return to idle. The snapshot is written only while the serializer is idle, so the transmission domain can read it without further synchronization. A frame-start request that arrives while a frame is in progress is held, and one new frame starts once the block is free again.

Top module: `tdc_array_readout`

## Requirements
- R1: After reset, pix_arm, pix_stop, ser_fsync, ser_valid and ser_data are all low, and nothing happens until frame_start is pulsed.
- R2: A frame_start pulse that arrives while the block is idle produces exactly one pix_arm pulse, one reference-clock cycle wide.
- R3: pix_stop is one reference-clock cycle wide and rises exactly QUANT_CYC+1 reference-clock cycles after pix_arm rises (3 cycles with the defaults).
- R4: ser_fsync is high for exactly one transmission-clock cycle, in the cycle just before the first payload bit. ser_valid is then high for exactly N_CH*(CODE_W+1) consecutive cycles (192 with the defaults).
- R5: The payload is sent channel 0 first and channel N_CH-1 last. Each channel's word is its hit flag followed by its CODE_W-bit code, most significant bit first, and channel k's code is pix_code[k*CODE_W +: CODE_W].
- R6: Pixel inputs are sampled on the reference-clock edge that ends the pix_stop cycle. Changes to the pixel inputs after that edge have no effect on the frame being sent.
- R7: frame_start pulses that arrive during a frame are merged into one pending request. That request starts exactly one further frame, and pix_arm never rises while a frame is being shifted out.
- R8: A single frame_start pulse placed at any reference-clock cycle around the end of a transmission produces exactly one further frame. It is neither lost nor doubled.
- R9: ser_data is low in every cycle in which ser_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for arming, quantization window and capture |
| tx_clk | input | 1 | Transmission clock for the serial readout |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| frame_start | input | 1 | Frame request, one reference-clock cycle wide |
| pix_hit | input | N_CH | Per-channel hit flag |
| pix_code | input | N_CH*CODE_W | Per-channel time code, channel k at bits k*CODE_W upward |
| pix_arm | output | 1 | Common arm strobe to all pixels |
| pix_stop | output | 1 | Common stop strobe ending the quantization window |
| ser_data | output | 1 | Serial payload bit |
| ser_valid | output | 1 | High while ser_data carries a payload bit |
| ser_fsync | output | 1 | One-cycle marker before the first payload bit |

## Verification
Two events can land on the same cycle: a new frame request and the reference side's return to idle once the completion level has crossed back from the transmission domain. The request can be captured as pending, accepted directly, or both. The bench ends one frame and then slides a single request across ten successive reference-clock offsets after the last payload bit, so every case of that collision is covered. For each offset it judges the result by counting frames on the serial line: exactly one further frame must appear, and no second frame may follow. A second case pulses the request repeatedly during a frame and expects one merged frame, with no arm strobe while payload is still on the line.

// File: rtl/tdcro_pkg.sv
package tdcro_pkg;

   // Reference-domain frame sequence
   typedef enum logic [2:0] {
      F_IDLE,
      F_ARM,
      F_QUANT,
      F_LATCH,
      F_XMIT
   } frame_st_t;

   // Transmission-domain serializer sequence
   typedef enum logic [1:0] {
      S_IDLE,
      S_SYNC,
      S_SHIFT,
      S_DONE
   } ser_st_t;

endpackage

// File: rtl/tdcro_sync.sv
module tdcro_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tdcro_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/tdcro_frame_ctrl.sv
module tdcro_frame_ctrl
   import tdcro_pkg::*;
#(
   parameter int N_CH      = 16,
   parameter int CODE_W    = 11,
   parameter int QUANT_CYC = 2,
   localparam int WORD_W   = CODE_W + 1,
   localparam int BITS     = N_CH * WORD_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     done_s,
   input  logic [N_CH-1:0]          pix_hit,
   input  logic [N_CH*CODE_W-1:0]   pix_code,
   output logic                     arm,
   output logic                     stop,
   output logic                     xmit_req,
   output logic [BITS-1:0]          frame_q
);

   localparam int QW = (QUANT_CYC > 1) ? $clog2(QUANT_CYC) : 1;

   frame_st_t        st;
   logic [QW-1:0]    qcnt;
   logic             pending;
   logic             go;
   logic [BITS-1:0]  pack_w;

   // Channel 0 occupies the top word so it leaves the serializer first
   for (genvar ch = 0; ch < N_CH; ch++) begin : g_pack
      assign pack_w[BITS-1-ch*WORD_W -: WORD_W] =
         {pix_hit[ch], pix_code[ch*CODE_W +: CODE_W]};
   end

   assign go = (start | pending) & ~done_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= F_IDLE;
         qcnt    <= '0;
         pending <= 1'b0;
         frame_q <= '0;
      end else begin
         if (st == F_IDLE && go) pending <= 1'b0;
         else if (start)         pending <= 1'b1;

         case (st)
            F_IDLE:  if (go) st <= F_ARM;
            F_ARM: begin
               st   <= F_QUANT;
               qcnt <= '0;
            end
            F_QUANT: begin
               if (qcnt == QW'(QUANT_CYC - 1)) st <= F_LATCH;
               else                            qcnt <= qcnt + 1'b1;
            end
            F_LATCH: begin
               st      <= F_XMIT;
               frame_q <= pack_w;
            end
            F_XMIT:  if (done_s) st <= F_IDLE;
            default: st <= F_IDLE;
         endcase
      end
   end

   assign arm      = (st == F_ARM);
   assign stop     = (st == F_LATCH);
   assign xmit_req = (st == F_XMIT);

   p_arm_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> !arm);

   p_stop_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !stop && xmit_req);

   p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xmit_req |=> $stable(frame_q));

   p_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && xmit_req) |=> pending);

endmodule

// File: rtl/tdcro_serializer.sv
module tdcro_serializer
   import tdcro_pkg::*;
#(
   parameter int BITS = 192,
   localparam int CW  = $clog2(BITS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_s,
   input  logic [BITS-1:0] frame,
   output logic            sdata,
   output logic            valid,
   output logic            fsync,
   output logic            done
);

   ser_st_t        st;
   logic [CW-1:0]  cnt;
   logic [CW-1:0]  idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= S_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            S_IDLE:  if (req_s) st <= S_SYNC;
            S_SYNC: begin
               st  <= S_SHIFT;
               cnt <= '0;
            end
            S_SHIFT: begin
               if (cnt == CW'(BITS - 1)) st <= S_DONE;
               else                      cnt <= cnt + 1'b1;
            end
            S_DONE:  if (!req_s) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign idx   = CW'(BITS - 1) - cnt;
   assign fsync = (st == S_SYNC);
   assign valid = (st == S_SHIFT);
   assign done  = (st == S_DONE);
   assign sdata = valid & frame[idx];

   p_fsync_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> valid && !fsync);

   p_valid_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && cnt != CW'(BITS - 1)) |=> valid);

   p_valid_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && cnt == CW'(BITS - 1)) |=> !valid && !fsync);

   p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> req_s);

endmodule

// File: rtl/tdc_array_readout.sv
module tdc_array_readout #(
   parameter int N_CH        = 16,
   parameter int CODE_W      = 11,
   parameter int QUANT_CYC   = 2,
   parameter int QUANT_MAX   = 2,
   parameter int SYNC_STAGES = 2,
   parameter int FRAME_TX    = 250,
   localparam int BITS       = N_CH * (CODE_W + 1)
) (
   input  logic                   ref_clk,
   input  logic                   tx_clk,
   input  logic                   rst_n,
   input  logic                   frame_start,
   input  logic [N_CH-1:0]        pix_hit,
   input  logic [N_CH*CODE_W-1:0] pix_code,
   output logic                   pix_arm,
   output logic                   pix_stop,
   output logic                   ser_data,
   output logic                   ser_valid,
   output logic                   ser_fsync
);

   if (N_CH < 1 || CODE_W < 1) begin : g_bad_width
      $error("tdc_array_readout: N_CH and CODE_W must be positive");
   end
   if (QUANT_CYC < 1 || QUANT_CYC > QUANT_MAX) begin : g_bad_window
      $error("tdc_array_readout: quantization window exceeds its range");
   end
   if (BITS + 1 > FRAME_TX) begin : g_bad_budget
      $error("tdc_array_readout: payload does not fit in one frame");
   end

   logic            xmit_req;
   logic            req_s;
   logic            done_tx;
   logic            done_s;
   logic [BITS-1:0] frame_q;

   tdcro_frame_ctrl #(
      .N_CH      (N_CH),
      .CODE_W    (CODE_W),
      .QUANT_CYC (QUANT_CYC)
   ) u_ctrl (
      .clk      (ref_clk),
      .rst_n    (rst_n),
      .start    (frame_start),
      .done_s   (done_s),
      .pix_hit  (pix_hit),
      .pix_code (pix_code),
      .arm      (pix_arm),
      .stop     (pix_stop),
      .xmit_req (xmit_req),
      .frame_q  (frame_q)
   );

   tdcro_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (tx_clk),
      .rst_n (rst_n),
      .d     (xmit_req),
      .q     (req_s)
   );

   tdcro_serializer #(.BITS(BITS)) u_ser (
      .clk   (tx_clk),
      .rst_n (rst_n),
      .req_s (req_s),
      .frame (frame_q),
      .sdata (ser_data),
      .valid (ser_valid),
      .fsync (ser_fsync),
      .done  (done_tx)
   );

   tdcro_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (done_tx),
      .q     (done_s)
   );

endmodule

// File: tb/tb_tdc_array_readout.sv
`timescale 1ns/1ps
module tb_tdc_array_readout;

   localparam int N_CH   = 16;
   localparam int CODE_W = 11;
   localparam int QC     = 2;
   localparam int WW     = CODE_W + 1;
   localparam int FB     = N_CH * WW;

   logic                   ref_clk = 1'b0;
   logic                   tx_clk  = 1'b0;
   logic                   rst_n   = 1'b0;
   logic                   frame_start = 1'b0;
   logic [N_CH-1:0]        pix_hit  = '0;
   logic [N_CH*CODE_W-1:0] pix_code = '0;
   logic pix_arm, pix_stop, ser_data, ser_valid, ser_fsync;

   int checks = 0;
   int errors = 0;

   always #4 ref_clk = ~ref_clk;
   always #2 tx_clk  = ~tx_clk;

   tdc_array_readout #(.N_CH(N_CH), .CODE_W(CODE_W), .QUANT_CYC(QC)) dut (
      .ref_clk(ref_clk), .tx_clk(tx_clk), .rst_n(rst_n),
      .frame_start(frame_start), .pix_hit(pix_hit), .pix_code(pix_code),
      .pix_arm(pix_arm), .pix_stop(pix_stop), .ser_data(ser_data),
      .ser_valid(ser_valid), .ser_fsync(ser_fsync));

   // ---------------- monitors ----------------
   int cyc = 0, arm_at = 0, last_gap = 0;
   int arm_cnt = 0, stop_cnt = 0, arm_wide = 0, stop_wide = 0;
   logic prev_arm = 1'b0, prev_stop = 1'b0;
   int overlap_err = 0;
   logic in_frame = 1'b0;

   always @(negedge ref_clk) begin
      cyc <= cyc + 1;
      if (pix_arm && !prev_arm) begin
         arm_cnt <= arm_cnt + 1;
         arm_at  <= cyc;
         if (in_frame) overlap_err <= overlap_err + 1;
      end
      if (pix_arm && prev_arm)   arm_wide  <= arm_wide + 1;
      if (pix_stop && !prev_stop) begin
         stop_cnt <= stop_cnt + 1;
         last_gap <= cyc - arm_at;
      end
      if (pix_stop && prev_stop) stop_wide <= stop_wide + 1;
      prev_arm  <= pix_arm;
      prev_stop <= pix_stop;
   end

   logic          prev_fsync = 1'b0;
   int            bitpos = 0, frames_rx = 0;
   int            lead_err = 0, fsync_err = 0, run_err = 0, idle_data_err = 0;
   logic [FB-1:0] rx_buf = '0, last_frame = '0;

   always @(negedge tx_clk) begin
      if (ser_fsync) in_frame <= 1'b1;
      if (ser_fsync && prev_fsync) fsync_err <= fsync_err + 1;
      if (!ser_valid && ser_data)  idle_data_err <= idle_data_err + 1;
      if (ser_valid) begin
         if (bitpos == 0 && !prev_fsync) lead_err <= lead_err + 1;
         rx_buf[FB-1-bitpos] = ser_data;
         if (bitpos == FB-1) begin
            last_frame <= rx_buf;
            frames_rx  <= frames_rx + 1;
            bitpos     <= 0;
            in_frame   <= 1'b0;
         end else begin
            bitpos <= bitpos + 1;
         end
      end else if (bitpos != 0) begin
         run_err <= run_err + 1;
         bitpos  <= 0;
      end
      prev_fsync <= ser_fsync;
   end

   // ---------------- helpers ----------------
   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_frame(string tag, logic [FB-1:0] act, logic [FB-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [FB-1:0] build_exp();
      logic [FB-1:0] v;
      for (int ch = 0; ch < N_CH; ch++)
         v[FB-1-ch*WW -: WW] = {pix_hit[ch], pix_code[ch*CODE_W +: CODE_W]};
      return v;
   endfunction

   task automatic set_pixels(int seed);
      for (int ch = 0; ch < N_CH; ch++) begin
         pix_hit[ch] = ((seed >> (ch % 8)) ^ ch) & 1;
         pix_code[ch*CODE_W +: CODE_W] = CODE_W'(seed * 37 + ch * 101 + (seed >> 3));
      end
   endtask

   task automatic pulse_start();
      @(negedge ref_clk) frame_start = 1'b1;
      @(negedge ref_clk) frame_start = 1'b0;
   endtask

   task automatic wait_frames(int target);
      int t = 0;
      while (frames_rx < target && t < 4000) begin
         @(negedge tx_clk);
         t++;
      end
   endtask

   task automatic idle_ref(int n);
      repeat (n) @(negedge ref_clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      idle_ref(20);
      chk("R1 arm low",   pix_arm,   0);
      chk("R1 stop low",  pix_stop,  0);
      chk("R1 valid low", ser_valid, 0);
      chk("R1 fsync low", ser_fsync, 0);
      chk("R1 data low",  ser_data,  0);
      chk("R1 no arm",    arm_cnt,   0);
      chk("R1 no frame",  frames_rx, 0);
   endtask

   task automatic t_basic(int seed);
      int a0, f0;
      logic [FB-1:0] exp;
      set_pixels(seed);
      exp = build_exp();
      a0 = arm_cnt; f0 = frames_rx;
      pulse_start();
      wait_frames(f0 + 1);
      idle_ref(4);
      chk("R2 one arm",    arm_cnt - a0, 1);
      chk("R3 arm to stop", last_gap, QC + 1);
      chk("R4 one frame",  frames_rx - f0, 1);
      chk_frame("R5 payload", last_frame, exp);
   endtask

   task automatic t_pattern(logic hit, logic [CODE_W-1:0] code);
      int f0;
      logic [FB-1:0] exp;
      pix_hit  = {N_CH{hit}};
      pix_code = {N_CH{code}};
      exp = build_exp();
      f0 = frames_rx;
      pulse_start();
      wait_frames(f0 + 1);
      chk_frame("R5 fixed pattern", last_frame, exp);
   endtask

   task automatic t_freeze();
      int f0, s0;
      logic [FB-1:0] expa, expb;
      set_pixels(91);
      expa = build_exp();
      f0 = frames_rx; s0 = stop_cnt;
      pulse_start();
      while (stop_cnt == s0) @(negedge ref_clk);
      idle_ref(2);
      set_pixels(200);
      expb = build_exp();
      wait_frames(f0 + 1);
      chk_frame("R6 frozen capture", last_frame, expa);
      pulse_start();
      wait_frames(f0 + 2);
      chk_frame("R6 next capture", last_frame, expb);
   endtask

   task automatic t_pending();
      int f0, a0, t;
      set_pixels(5);
      f0 = frames_rx; a0 = arm_cnt;
      pulse_start();
      t = 0;
      while (bitpos < 20 && t < 4000) begin @(negedge tx_clk); t++; end
      pulse_start();
      idle_ref(3);
      pulse_start();
      wait_frames(f0 + 2);
      idle_ref(600);
      chk("R7 merged frames", frames_rx - f0, 2);
      chk("R7 merged arms",   arm_cnt - a0, 2);
      chk("R7 no arm during frame", overlap_err, 0);
   endtask

   task automatic t_boundary();
      for (int d = 0; d < 10; d++) begin
         int f0;
         f0 = frames_rx;
         pulse_start();
         wait_frames(f0 + 1);
         idle_ref(d);
         pulse_start();
         wait_frames(f0 + 2);
         idle_ref(400);
         chk($sformatf("R8 offset %0d", d), frames_rx - f0, 2);
      end
   endtask

   task automatic t_hygiene();
      chk("R2 arm width",    arm_wide,  0);
      chk("R3 stop width",   stop_wide, 0);
      chk("R4 fsync lead",   lead_err,  0);
      chk("R4 fsync width",  fsync_err, 0);
      chk("R4 valid run",    run_err,   0);
      chk("R9 idle data",    idle_data_err, 0);
   endtask

   // ---------------- main ----------------
   initial begin
      repeat (3) @(negedge ref_clk);
      rst_n = 1'b1;
      t_reset();
      t_basic(1);
      t_basic(77);
      t_basic(1234);
      t_pattern(1'b1, '1);
      t_pattern(1'b0, '0);
      t_pattern(1'b1, CODE_W'(11'h555));
      t_freeze();
      t_pending();
      t_boundary();
      t_hygiene();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge tx_clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule